// File: doc/BRIEF.md
# Execution-Unit Activity Monitor

This block sits at the execute stage of a pipeline that feeds several execution units. Every cycle it reads one 2-bit dispatch status per unit. It then returns each occupied slot to empty by raising a strobe for that unit. A slot that is ready to run raises both an execute strobe and a release strobe. A slot marked to be skipped raises only the release strobe. The strobes are combinational, so they appear in the same cycle as the status.

Alongside the strobes the block gathers performance statistics in saturating counters:

- busy and idle cycles for each unit;
- whole-stage active and idle cycles;
- transitions from active to idle;
- a histogram of idle-run lengths;
- a histogram of how many units are busy in a cycle.

Software reads any counter through an indexed read port. A synchronous clear zeroes every counter together with the idle-tracking state.

Unit indices are fixed by type. The vector ALUs come first, then the scalar ALUs, then the vector memory pipe, the shared memory pipe and the scalar memory pipe. With the defaults there are four vector ALUs and one scalar ALU, which gives eight units.

Top module: `exec_activity_monitor`

## Requirements
- R1: Unit u's status is `slot_status[2u+1:2u]`, coded 0 = empty, 1 = skip, 2 = ready. Code 3 is treated as empty. An empty unit raises neither strobe.
- R2: A ready unit raises `exec_strobe[u]` and `release_strobe[u]` in the same cycle as the status.
- R3: A skip unit raises `release_strobe[u]` only, and its `exec_strobe[u]` stays low.
- R4: In each cycle the busy counter of a unit increments when its status is skip or ready. Otherwise the unit's idle counter increments.
- R5: A cycle is active when at least one unit is busy. Active cycles and idle cycles each increment their own counter.
- R6: The transition counter increments on each cycle that is idle when the cycle before it was active. The state before the first cycle counts as idle.
- R7: An idle-run count grows on each idle cycle. On an active cycle with a non-zero run, the run is recorded in the idle histogram and then reset.
  - A run of length L goes to bin L/5 when L < 75.
  - A run of 75 or more goes to overflow bin 15.
- R8: Each cycle, the number of busy units k (0..N) increments busy-histogram bin k.
- R9: Every counter saturates at all-ones and never wraps.
- R10: While `clr` is high at a clock edge, every counter, the idle-run count and the previous-active flag go to zero, and nothing is counted in that cycle.
- R11: `rd_data` presents the counter addressed by `rd_addr` one cycle later. Addresses outside the map read zero. The value returned is the one held before that edge's update. With N units the map is:

| Address | Counter |
|---|---|
| u | busy count of unit u |
| N+u | idle count of unit u |
| 2N | active cycles |
| 2N+1 | idle cycles |
| 2N+2 | active-to-idle transitions |
| 2N+3+b | idle-histogram bin b (b = 0..15) |
| 2N+19+k | busy-histogram bin k |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| slot_status | input | 2*N | Per-unit dispatch status codes |
| exec_strobe | output | N | Per-unit execute strobe |
| release_strobe | output | N | Per-unit resource-release strobe |
| rd_addr | input | ADDR_W | Counter read address |
| rd_data | output | CNT_W | Counter read data, one-cycle latency |

## Verification
The bench aims at the idle-histogram bin edges:

- Runs of 74, 75 and 80 cycles check the overflow boundary. An off-by-one bin computation would place the 75-cycle run in bin 14.
- Recording must wait for activity to resume. A design that recorded at the start of an idle run would fill bin 0 with spurious entries.

Other corner cases each have a direct test:

- A skip slot must not fire an execute strobe, and code 3 must behave as empty.
- A run of 260 busy cycles on 8-bit counters exposes a counter that wraps instead of saturating.
- A cleared design that kept its idle-run count or previous-active flag would bin the first run after the clear incorrectly, or miscount transitions.

// File: rtl/exec_activity_monitor.sv
module exec_activity_monitor #(
  parameter int NUM_VALU  = 4,
  parameter int NUM_SALU  = 1,
  parameter int CNT_W     = 16,
  parameter int IDLE_SPAN = 75,
  parameter int IDLE_STEP = 5,
  parameter int ADDR_W    = 6,
  localparam int NU        = NUM_VALU + NUM_SALU + 3,
  localparam int IDLE_BINS = IDLE_SPAN / IDLE_STEP + 1,
  localparam int A_ACT     = 2 * NU,
  localparam int A_IDL     = 2 * NU + 1,
  localparam int A_TRN     = 2 * NU + 2,
  localparam int A_IH      = 2 * NU + 3,
  localparam int A_BH      = A_IH + IDLE_BINS,
  localparam int TOTAL     = A_BH + NU + 1,
  localparam int BW        = $clog2(NU + 1),
  localparam int IB_W      = $clog2(IDLE_BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [2*NU-1:0]   slot_status,
  output logic [NU-1:0]     exec_strobe,
  output logic [NU-1:0]     release_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [NU-1:0]    busy;
  logic             active;
  logic             prev_active;
  logic [CNT_W-1:0] run_len;
  logic [BW-1:0]    nbusy;
  logic [IB_W-1:0]  bin;
  logic             record;
  logic [TOTAL-1:0] inc;
  logic [CNT_W-1:0] cnt [TOTAL];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    wire [1:0] code = slot_status[2*u +: 2];
    assign exec_strobe[u]    = (code == 2'd2);
    assign release_strobe[u] = (code == 2'd1) || (code == 2'd2);
    assign busy[u]           = release_strobe[u];
  end

  assign active = |busy;
  assign nbusy  = BW'($countones(busy));
  assign record = active && (run_len != '0);
  assign bin    = (run_len >= CNT_W'(IDLE_SPAN)) ? IB_W'(IDLE_BINS - 1)
                                                 : IB_W'(run_len / CNT_W'(IDLE_STEP));

  always_comb begin
    inc = '0;
    for (int u = 0; u < NU; u++) begin
      inc[u]      = busy[u];
      inc[NU + u] = !busy[u];
    end
    inc[A_ACT] = active;
    inc[A_IDL] = !active;
    inc[A_TRN] = prev_active && !active;
    if (record) inc[A_IH + int'(bin)] = 1'b1;
    inc[A_BH + int'(nbusy)] = 1'b1;
  end

  for (genvar g = 0; g < TOTAL; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt[g] <= '0;
      else if (clr)                      cnt[g] <= '0;
      else if (inc[g] && cnt[g] != MAXV) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_active <= 1'b0;
      run_len     <= '0;
    end else if (clr) begin
      prev_active <= 1'b0;
      run_len     <= '0;
    end else begin
      prev_active <= active;
      if (active)               run_len <= '0;
      else if (run_len != MAXV) run_len <= run_len + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_data <= '0;
    else if (int'(rd_addr) < TOTAL)  rd_data <= cnt[rd_addr];
    else                             rd_data <= '0;
  end

endmodule

module exec_activity_monitor_chk #(
  parameter int NU    = 8,
  parameter int TOTAL = 44,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [2*NU-1:0]  slot_status,
  input logic [NU-1:0]    exec_strobe,
  input logic [NU-1:0]    release_strobe,
  input logic [CNT_W-1:0] rd_data,
  input logic [CNT_W-1:0] cnt [TOTAL]
);

  for (genvar u = 0; u < NU; u++) begin : g_u
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_status[2*u +: 2] == 2'd0 || slot_status[2*u +: 2] == 2'd3) |-> !release_strobe[u] && !exec_strobe[u]); // R1
    AST_READY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_status[2*u +: 2] == 2'd2) |-> exec_strobe[u] && release_strobe[u]); // R2
    AST_SKIP_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_status[2*u +: 2] == 2'd1) |-> release_strobe[u] && !exec_strobe[u]); // R3
  end

  for (genvar g = 0; g < TOTAL; g++) begin : g_c
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt[g] == '1) |=> cnt[g] == '1); // R9
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr, 2) |-> rd_data == '0); // R10

endmodule

bind exec_activity_monitor exec_activity_monitor_chk #(.NU(NU), .TOTAL(TOTAL), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .slot_status(slot_status),
  .exec_strobe(exec_strobe), .release_strobe(release_strobe),
  .rd_data(rd_data), .cnt(cnt)
);

// File: tb/exec_activity_monitor_tb.sv
module exec_activity_monitor_tb_top;
  localparam int NU = 8;
  localparam int CW = 8;
  localparam int TOT = 44;
  localparam int A_ACT = 16, A_IDL = 17, A_TRN = 18, A_IH = 19, A_BH = 35;
  localparam int MAXV = 255;

  logic clk = 0, rst_n = 0, clr = 0;
  logic [2*NU-1:0] slot_status = '0;
  logic [NU-1:0] exec_strobe, release_strobe;
  logic [5:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  int m [TOT];
  int mrun = 0;
  bit mprev = 0;

  always #5 clk = ~clk;

  exec_activity_monitor #(.NUM_VALU(4), .NUM_SALU(1), .CNT_W(CW), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .slot_status(slot_status),
    .exec_strobe(exec_strobe), .release_strobe(release_strobe),
    .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic void bump(int a);
    if (m[a] < MAXV) m[a]++;
  endfunction

  function automatic void model(logic [2*NU-1:0] s, logic c);
    int k = 0;
    bit act;
    if (c) begin
      foreach (m[i]) m[i] = 0;
      mrun = 0; mprev = 0;
      return;
    end
    for (int u = 0; u < NU; u++) begin
      bit b = (s[2*u +: 2] == 2'd1) || (s[2*u +: 2] == 2'd2);
      if (b) begin bump(u); k++; end else bump(NU + u);
    end
    act = (k != 0);
    if (act) bump(A_ACT); else bump(A_IDL);
    if (mprev && !act) bump(A_TRN);
    if (act && mrun != 0) bump(A_IH + ((mrun >= 75) ? 15 : mrun / 5));
    bump(A_BH + k);
    if (act) mrun = 0; else if (mrun < MAXV) mrun++;
    mprev = act;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(logic [2*NU-1:0] s, logic c);
    slot_status = s; clr = c;
    model(s, c);
    @(negedge clk);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) drive('0, 0);
  endtask

  task automatic rd(int a, string req);
    int exp;
    rd_addr = 6'(a);
    exp = (a < TOT) ? m[a] : 0;
    drive('0, 0);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic rd_lit(int a, int exp, string req);
    rd_addr = 6'(a);
    drive('0, 0);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    chk("R1 reset exec", int'(exec_strobe), 0);
    chk("R1 reset release", int'(release_strobe), 0);
    rd_lit(0, 0, "R11 reset busy0");
    rd_lit(A_TRN, 0, "R11 reset trn");
  endtask

  task automatic t_strobes;
    logic [2*NU-1:0] s;
    s = {2'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd0, 2'd2};
    slot_status = s; #1;
    chk("R2 exec pattern", int'(exec_strobe), 8'b0001_1001);
    chk("R3 release pattern", int'(release_strobe), 8'b0011_1101);
    chk("R1 code3 quiet", int'(release_strobe[7]), 0);
    drive(s, 0);
    s = {NU{2'd1}};
    slot_status = s; #1;
    chk("R3 all skip no exec", int'(exec_strobe), 0);
    chk("R3 all skip release", int'(release_strobe), 8'hFF);
    drive(s, 0);
  endtask

  task automatic t_unit_counts;
    drive('0, 1);
    drive({2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2}, 0);
    drive({2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2}, 0);
    drive({2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1}, 0);
    rd_lit(0, 3, "R4 busy unit0");
    rd_lit(1, 1, "R4 busy unit1 skip");
    rd(NU + 7, "R4 idle unit7 incl code3");
    rd(7, "R4 busy unit7 smem");
    rd(A_ACT, "R5 active cycles");
    rd(A_IDL, "R5 idle cycles");
  endtask

  task automatic t_trans;
    logic [2*NU-1:0] a;
    a = 16'h0002;
    drive('0, 1);
    drive(a, 0); drive('0, 0); drive(a, 0); drive(a, 0);
    drive('0, 0); drive('0, 0); drive(a, 0);
    rd_lit(A_TRN, 2, "R6 transitions");
    rd(A_TRN, "R6 transitions after read");
  endtask

  task automatic t_idle_hist;
    logic [2*NU-1:0] a;
    a = 16'h0001;
    drive('0, 1);
    drive(a, 0);
    idle_n(3);  drive(a, 0);
    idle_n(7);  drive(a, 0);
    idle_n(74); drive(a, 0);
    idle_n(75); drive(a, 0);
    idle_n(80); drive(a, 0);
    rd_lit(A_IH + 0, 1, "R7 bin0");
    rd_lit(A_IH + 1, 1, "R7 bin1");
    rd_lit(A_IH + 14, 1, "R7 bin14 len74");
    rd_lit(A_IH + 15, 2, "R7 overflow bin");
    rd_lit(A_IH + 2, 0, "R7 no record while idle");
  endtask

  task automatic t_busy_hist;
    drive('0, 1);
    drive({NU{2'd2}}, 0);
    drive({NU{2'd1}}, 0);
    drive(16'h0015, 0);
    drive('0, 0);
    rd_lit(A_BH + 8, 2, "R8 bin8");
    rd_lit(A_BH + 3, 1, "R8 bin3");
    rd(A_BH + 0, "R8 bin0");
  endtask

  task automatic t_sat;
    drive('0, 1);
    for (int i = 0; i < 260; i++) drive(16'h0002, 0);
    rd_lit(0, MAXV, "R9 busy saturates");
    rd_lit(A_BH + 1, MAXV, "R9 hist saturates");
    rd_lit(NU + 3, MAXV, "R9 idle saturates");
  endtask

  task automatic t_clear;
    drive(16'h0002, 0);
    idle_n(20);
    drive('0, 1);
    idle_n(3);
    drive(16'h0002, 0);
    rd_lit(A_IH + 0, 1, "R10 run restarted");
    rd_lit(A_IH + 4, 0, "R10 no stale run");
    rd_lit(A_TRN, 1, "R10 prev flag cleared");
    rd_lit(60, 0, "R11 out of range");
  endtask

  initial begin
    foreach (m[i]) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model('0, 0);
    t_reset;
    t_strobes;
    t_unit_counts;
    t_trans;
    t_idle_hist;
    t_busy_hist;
    t_sat;
    t_clear;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule